// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects up to eight peripheral request lines and presents them to a processor that has one interrupt request input and one acknowledge output. Software configures it through an 8-bit host bus with chip select, read and write strobes and a single register-select bit `a0_i`. Inside it keeps a request register, an in-service register and a mask register. Priority among the inputs is fixed, with input 0 highest and input 7 lowest.

After reset the host writes an ordered sequence of setup words. The first word selects edge or level detection and says which of the optional words follow. The next word sets a 5-bit vector base. When the processor acknowledges, it gives two pulses. The first pulse selects the winning input and marks it in service. The second pulse puts the vector on the data output: the base in the upper five bits and the input number in the lower three. Software then retires the interrupt with an end-of-service command, or lets the controller retire it by itself.

All strobes are synchronous to `clk_i`. A strobe or acknowledge pulse counts once for each clock edge at which it is high.

Top module: `vint_ctrl`

## Requirements
- R1: A setup word is a write with `a0_i`=0 and bit 4=1. Writes with `a0_i`=1 then fill the remaining words in a fixed order: the vector base, then a cascade word (ignored) only when bit 1 of the setup word was 0, then a mode word only when bit 0 was 1. `int_o` stays low until the sequence is complete. After that, a write with `a0_i`=1 loads the mask.
- R2: A setup word sets level detection when bit 3=1 and edge detection when bit 3=0. It clears the mask, the in-service register and the pending edge latches. It turns automatic retire off and selects the request register for reads.
- R3: On the second acknowledge pulse `data_o` equals {base bits 7:3, index of the serviced input}. During the first pulse `data_o` is 0.
- R4: A mask bit of 1 stops its input from raising `int_o`. A 0 lets it through.
- R5: `int_o` rises one clock after an unmasked request appears, but only if that request's index is lower than every index in service. Input 0 has the highest priority.
- R6: The first acknowledge pulse sets the in-service bit of the highest-priority qualifying request and clears its edge latch.
- R7: A write with `a0_i`=0 and bits 4:3=00 is a retire command when bit 5=1. With bit 6=0 it clears the highest-priority in-service bit. With bit 6=1 it clears the in-service bit whose index is in bits 2:0. With bit 5=0 it changes nothing.
- R8: When bit 1 of the mode word is 1, the in-service bit clears at the end of the second acknowledge pulse.
- R9: A write with `a0_i`=0 and bits 4:3=01 is a read-select command. Bits 1:0=10 select the request register and 11 select the in-service register; any other value keeps the current choice. A read with `a0_i`=0 returns the selected register, and a read with `a0_i`=1 returns the mask. With no read and no second acknowledge pulse, `data_o` is 0.
- R10: In level mode a high line is a request. If the line is still high after its interrupt is retired, `int_o` rises again.
- R11: In edge mode only a low-to-high transition is latched. The latch holds after the line falls, and a line that stays high does not latch again.
- R12: If no request qualifies at the first acknowledge pulse, the vector carries index 7 and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select for host access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| a0_i | input | 1 | Register select bit |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Read data or vector byte |
| irq_i | input | 8 | Peripheral request lines |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
If the in-service register is wrong, the damage shows at `int_o` within one clock: a request that should preempt stays silent, or a lower-priority one gets through. A wrong edge latch or a wrong setup-sequence state shows the same way. A bad stored index shows only on the second acknowledge pulse, as a wrong vector byte. A stuck in-service bit shows on the next in-service read or on the next request that needs to be granted. The bench sweeps the vector base against every input index, then drives nesting, retire commands, masking and both detection modes, and reads the registers back through the host bus after each step.

// File: rtl/vint_pkg.sv
package vint_pkg;
  typedef enum logic [2:0] {
    CFG_OFF,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;
endpackage

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/vint_req.sv
module vint_req #(
  parameter int unsigned NUM_IN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic              init_i,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic [NUM_IN-1:0] take_i,
  output logic [NUM_IN-1:0] irr_o
);
  for (genvar g = 0; g < NUM_IN; g++) begin : g_line
    logic line_q, edge_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q <= 1'b0;
        edge_q <= 1'b0;
      end else begin
        line_q <= irq_i[g];
        if (init_i || take_i[g]) edge_q <= 1'b0;
        else if (irq_i[g] && !line_q) edge_q <= 1'b1;
      end
    end

    assign irr_o[g] = level_i ? line_q : edge_q;

    assert_edge_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i && irr_o[g] && !init_i && !take_i[g]) |=> irr_o[g]);

    assert_no_relatch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i && !irr_o[g] && line_q && irq_i[g]) |=> !irr_o[g]);
  end
endmodule

// File: rtl/vint_cfg.sv
module vint_cfg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_IN = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IN),
  localparam int unsigned BASE_W = DATA_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              level_o,
  output logic              aeoi_o,
  output logic [BASE_W-1:0] base_o,
  output logic [NUM_IN-1:0] mask_o,
  output logic              rsel_isr_o,
  output logic              init_o,
  output logic              eoi_o,
  output logic              eoi_spec_o,
  output logic [IDX_W-1:0]  eoi_idx_o
);
  import vint_pkg::*;

  cfg_state_e state_q;
  logic       need_casc_q, need_mode_q;

  logic first_w, cmd_w, data_w;
  assign first_w = wr_en_i && !a0_i && wdata_i[4];
  assign cmd_w   = wr_en_i && !a0_i && !wdata_i[4];
  assign data_w  = wr_en_i && a0_i;

  assign init_o     = first_w;
  assign run_o      = (state_q == CFG_RUN);
  assign eoi_o      = cmd_w && !wdata_i[3] && wdata_i[5] && run_o;
  assign eoi_spec_o = wdata_i[6];
  assign eoi_idx_o  = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= CFG_OFF;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      level_o     <= 1'b0;
      aeoi_o      <= 1'b0;
      base_o      <= '0;
      mask_o      <= '0;
      rsel_isr_o  <= 1'b0;
    end else if (first_w) begin
      state_q     <= CFG_BASE;
      level_o     <= wdata_i[3];
      need_casc_q <= !wdata_i[1];
      need_mode_q <= wdata_i[0];
      aeoi_o      <= 1'b0;
      mask_o      <= '0;
      rsel_isr_o  <= 1'b0;
    end else if (data_w) begin
      unique case (state_q)
        CFG_BASE: begin
          base_o  <= wdata_i[DATA_W-1:IDX_W];
          state_q <= need_casc_q ? CFG_CASC : (need_mode_q ? CFG_MODE : CFG_RUN);
        end
        CFG_CASC: state_q <= need_mode_q ? CFG_MODE : CFG_RUN;
        CFG_MODE: begin
          aeoi_o  <= wdata_i[1];
          state_q <= CFG_RUN;
        end
        CFG_RUN:  mask_o <= wdata_i[NUM_IN-1:0];
        default:  ;
      endcase
    end else if (cmd_w && wdata_i[3] && wdata_i[1] && run_o) begin
      rsel_isr_o <= wdata_i[0];
    end
  end

  assert_seq_short_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_w && !first_w && state_q == CFG_BASE && !need_casc_q && !need_mode_q) |=> run_o);

  assert_seq_casc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_w && !first_w && state_q == CFG_BASE && need_casc_q) |=> (state_q == CFG_CASC));

  assert_setup_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_w |=> (state_q == CFG_BASE && mask_o == '0 && !aeoi_o));
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_IN = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IN),
  localparam int unsigned BASE_W = DATA_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic              inta_i,
  output logic              int_o
);
  logic              run, level, aeoi, rsel_isr, init, eoi, eoi_spec;
  logic [BASE_W-1:0] base;
  logic [NUM_IN-1:0] mask, irr, take_vec;
  logic [IDX_W-1:0]  eoi_idx;

  vint_cfg #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cs_i && wr_i),
    .a0_i       (a0_i),
    .wdata_i    (data_i),
    .run_o      (run),
    .level_o    (level),
    .aeoi_o     (aeoi),
    .base_o     (base),
    .mask_o     (mask),
    .rsel_isr_o (rsel_isr),
    .init_o     (init),
    .eoi_o      (eoi),
    .eoi_spec_o (eoi_spec),
    .eoi_idx_o  (eoi_idx)
  );

  vint_req #(.NUM_IN(NUM_IN)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level),
    .init_i  (init),
    .irq_i   (irq_i),
    .take_i  (take_vec),
    .irr_o   (irr)
  );

  logic [NUM_IN-1:0] isr_q, isr_n;
  logic              pend_v, isr_v;
  logic [IDX_W-1:0]  pend_idx, isr_idx;

  vint_prio #(.N(NUM_IN)) u_prio_pend (
    .vec_i   (irr & ~mask),
    .valid_o (pend_v),
    .idx_o   (pend_idx)
  );

  vint_prio #(.N(NUM_IN)) u_prio_svc (
    .vec_i   (isr_q),
    .valid_o (isr_v),
    .idx_o   (isr_idx)
  );

  logic             phase_q, spur_q;
  logic [IDX_W-1:0] cur_idx_q;
  logic             grant, ack_first, ack_second;

  // a request only preempts strictly lower-priority service
  assign grant      = run && pend_v && (!isr_v || pend_idx < isr_idx);
  assign int_o      = grant;
  assign ack_first  = inta_i && !phase_q;
  assign ack_second = inta_i && phase_q;

  always_comb begin
    take_vec = '0;
    if (ack_first && grant) take_vec[pend_idx] = 1'b1;
  end

  always_comb begin
    isr_n = isr_q;
    if (ack_first && grant) isr_n[pend_idx] = 1'b1;
    if (ack_second && aeoi && !spur_q) isr_n[cur_idx_q] = 1'b0;
    if (eoi) begin
      if (eoi_spec) isr_n[eoi_idx] = 1'b0;
      else if (isr_v) isr_n[isr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q     <= '0;
      phase_q   <= 1'b0;
      spur_q    <= 1'b0;
      cur_idx_q <= '0;
    end else if (init) begin
      isr_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      isr_q <= isr_n;
      if (inta_i) phase_q <= !phase_q;
      if (ack_first) begin
        cur_idx_q <= grant ? pend_idx : '1;
        spur_q    <= !grant;
      end
    end
  end

  always_comb begin
    data_o = '0;
    if (ack_second) data_o = {base, cur_idx_q};
    else if (cs_i && rd_i && !inta_i) begin
      if (a0_i) data_o = DATA_W'(mask);
      else if (rsel_isr) data_o = DATA_W'(isr_q);
      else data_o = DATA_W'(irr);
    end
  end

  assert_grant_sets_isr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_first && grant && !eoi && !init) |=> isr_q[$past(pend_idx)]);

  assert_auto_retire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_second && aeoi && !spur_q && !init) |=> !isr_q[$past(cur_idx_q)]);

  assert_spurious_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_first && !grant && !eoi && !init) |=> ($stable(isr_q) && cur_idx_q == '1));

  assert_int_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(irr & ~mask)));

  assert_int_nested_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !isr_q[pend_idx]);
endmodule

// File: tb/vint_ctrl_tb.sv
module vint_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, a0 = 1'b0, inta = 1'b0;
  logic [7:0] din = '0, irq = '0;
  logic [7:0] dout;
  logic       intr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  vint_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd), .a0_i(a0),
    .data_i(din), .data_o(dout), .irq_i(irq), .inta_i(inta), .int_o(intr)
  );

  // {base word, input index}
  localparam logic [10:0] VEC_TAB [8] = '{
    {8'h08, 3'd0}, {8'h0F, 3'd1}, {8'h70, 3'd2}, {8'hF8, 3'd3},
    {8'h27, 3'd4}, {8'h48, 3'd5}, {8'hA0, 3'd6}, {8'hD9, 3'd7}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_word(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; a0 = sel; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; a0 = 1'b0; din = '0;
    #1;
  endtask

  task automatic rd_word(input logic sel, output logic [7:0] v);
    cs = 1'b1; rd = 1'b1; a0 = sel;
    #1;
    v = dout;
    cs = 1'b0; rd = 1'b0; a0 = 1'b0;
  endtask

  task automatic ack(output logic [7:0] first_v, output logic [7:0] vec);
    @(negedge clk); inta = 1'b1; #1 first_v = dout;
    @(negedge clk); inta = 1'b0;
    @(negedge clk); inta = 1'b1; #1 vec = dout;
    @(negedge clk); inta = 1'b0;
    #1;
  endtask

  task automatic setup(input logic lvl, input logic [7:0] base, input logic single,
                       input logic has_mode, input logic auto_ret);
    wr_word(1'b0, {3'b000, 1'b1, lvl, 1'b0, single, has_mode});
    wr_word(1'b1, base);
    if (!single) wr_word(1'b1, 8'h00);
    if (has_mode) wr_word(1'b1, {6'b0, auto_ret, 1'b1});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset data_o idle", dout, 8'h00);
    chk("R1 reset int_o", {7'b0, intr}, 8'h00);
    rd_word(1'b1, v); chk("R2 reset mask", v, 8'h00);

    // table sweep: vector base against every index (R3 R5 R6 R7 R11)
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      logic [2:0] k;
      b = VEC_TAB[i][10:3];
      k = VEC_TAB[i][2:0];
      setup(1'b0, b, 1'b1, 1'b1, 1'b0);
      @(negedge clk); irq[k] = 1'b1;
      step();
      chk("R5 int on request", {7'b0, intr}, 8'h01);
      ack(f, v);
      chk("R3 first pulse data", f, 8'h00);
      chk("R3 vector", v, {b[7:3], k});
      wr_word(1'b0, 8'h0B);
      rd_word(1'b0, v); chk("R6 in-service bit", v, 8'(1) << k);
      chk("R11 held line no relatch", {7'b0, intr}, 8'h00);
      wr_word(1'b0, 8'h20);
      rd_word(1'b0, v); chk("R7 nonspecific retire", v, 8'h00);
      @(negedge clk); irq = '0;
    end

    // R1: cascade word present, no mode word
    wr_word(1'b0, 8'h10);
    wr_word(1'b1, 8'h40);
    @(negedge clk); irq[0] = 1'b1;
    step();
    chk("R1 int held until sequence done", {7'b0, intr}, 8'h00);
    wr_word(1'b1, 8'h00);
    chk("R1 int after cascade word", {7'b0, intr}, 8'h01);
    ack(f, v);
    chk("R1 vector after sequence", v, 8'h40);
    wr_word(1'b0, 8'h20);
    wr_word(1'b1, 8'h02);
    rd_word(1'b1, v); chk("R1 mask load after setup", v, 8'h02);
    @(negedge clk); irq = '0;

    // R4 masking with edge latch held
    @(negedge clk); irq[1] = 1'b1;
    step();
    chk("R4 masked input silent", {7'b0, intr}, 8'h00);
    @(negedge clk); irq[1] = 1'b0;
    wr_word(1'b1, 8'h00);
    chk("R4 unmask releases latched edge R11", {7'b0, intr}, 8'h01);
    ack(f, v);
    chk("R4 vector after unmask", v, 8'h41);
    wr_word(1'b0, 8'h20);

    // R2: setup word clears mask
    wr_word(1'b1, 8'hFF);
    setup(1'b0, 8'h08, 1'b1, 1'b1, 1'b0);
    rd_word(1'b1, v); chk("R2 setup clears mask", v, 8'h00);

    // nesting, retire commands, read select
    @(negedge clk); irq[5] = 1'b1;
    step();
    ack(f, v); chk("R6 first grant", v, 8'h0D);
    @(negedge clk); irq[2] = 1'b1;
    step();
    chk("R5 higher priority preempts", {7'b0, intr}, 8'h01);
    ack(f, v); chk("R5 nested vector", v, 8'h0A);
    wr_word(1'b0, 8'h0B);
    rd_word(1'b0, v); chk("R6 nested in-service", v, 8'h24);
    wr_word(1'b0, 8'h00);
    rd_word(1'b0, v); chk("R7 bit5 clear no effect", v, 8'h24);
    @(negedge clk); irq[6] = 1'b1;
    step();
    chk("R5 lower priority blocked", {7'b0, intr}, 8'h00);
    wr_word(1'b0, 8'h0A);
    rd_word(1'b0, v); chk("R9 request register", v, 8'h40);
    wr_word(1'b0, 8'h08);
    rd_word(1'b0, v); chk("R9 select kept", v, 8'h40);
    wr_word(1'b0, 8'h0B);
    wr_word(1'b0, 8'h20);
    rd_word(1'b0, v); chk("R7 nonspecific clears top", v, 8'h20);
    chk("R5 still blocked by 5", {7'b0, intr}, 8'h00);
    wr_word(1'b0, 8'h65);
    rd_word(1'b0, v); chk("R7 specific retire", v, 8'h00);
    chk("R5 int after retire", {7'b0, intr}, 8'h01);
    ack(f, v); chk("R3 vector input 6", v, 8'h0E);
    wr_word(1'b0, 8'h20);
    @(negedge clk); irq = '0;

    // R10 level mode
    setup(1'b1, 8'h10, 1'b1, 1'b1, 1'b0);
    @(negedge clk); irq[3] = 1'b1;
    step();
    chk("R10 level request", {7'b0, intr}, 8'h01);
    ack(f, v); chk("R10 level vector", v, 8'h13);
    chk("R10 quiet while in service", {7'b0, intr}, 8'h00);
    wr_word(1'b0, 8'h20);
    chk("R10 reassert after retire", {7'b0, intr}, 8'h01);
    ack(f, v); chk("R10 second vector", v, 8'h13);
    @(negedge clk); irq[3] = 1'b0;
    wr_word(1'b0, 8'h20);
    chk("R10 line low no int", {7'b0, intr}, 8'h00);

    // R12 request withdrawn before acknowledge
    @(negedge clk); irq[4] = 1'b1;
    step();
    chk("R12 request seen", {7'b0, intr}, 8'h01);
    @(negedge clk); irq[4] = 1'b0;
    ack(f, v); chk("R12 default vector", v, 8'h17);
    wr_word(1'b0, 8'h0B);
    rd_word(1'b0, v); chk("R12 no in-service bit", v, 8'h00);

    // R8 automatic retire
    setup(1'b0, 8'h30, 1'b1, 1'b1, 1'b1);
    @(negedge clk); irq[1] = 1'b1;
    step();
    ack(f, v); chk("R8 vector", v, 8'h31);
    wr_word(1'b0, 8'h0B);
    rd_word(1'b0, v); chk("R8 in-service cleared", v, 8'h00);

    // R11 edge relatch after line falls
    @(negedge clk); irq[1] = 1'b0;
    step();
    chk("R11 low line no int", {7'b0, intr}, 8'h00);
    @(negedge clk); irq[1] = 1'b1;
    step();
    chk("R11 new edge latched", {7'b0, intr}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule